// File: doc/BRIEF.md
# SPI Flash Menu-Driven Command Sequencer

This block is a register-driven SPI flash command engine. Software does not hand it a raw opcode. It loads an eight-entry table of opcodes and, for each entry, a two-bit operation type, and then starts a cycle by naming a table index. The engine builds the whole SPI frame on its own. The frame holds the opcode, a 24-bit address taken from the shared flash address input when the entry's type carries one, and an optional data phase of 1 to 64 bytes. The data phase moves bytes to or from a shared 64-byte data buffer.

Two prefix opcodes, for example write-enable, are stored next to the type table. When atomic mode is requested, the selected prefix goes out in its own chip-select frame. The main frame follows after a fixed short deselect time, and software does nothing between the two frames. Status is reported through busy, done, cycle-error and access-error flags. Software clears a flag by writing one to it, and an optional interrupt request follows the done flag. A lock input from the neighbouring hardware sequencer freezes the opcode table and the prefix/type word.

Top module: `flash_menu_seq`

## Requirements
- R1: After reset the chip select is high, SCK is low, busy/done/error flags are 0, and all four registers read 0.
- R2: Register 0 (control/status) reads back: bit 0 busy, bit 2 done, bit 3 cycle error, bit 4 access error, bit 10 atomic, bit 11 prefix select, bits 14:12 menu index, bits 21:16 byte count minus one, bit 22 data enable, bit 23 interrupt enable. Go (bit 9) and every other bit read 0.
- R3: Menu entry i is byte i%4 of register 2 (entries 0-3) or register 3 (entries 4-7), lowest byte first. Its type is bits 17+2i:16+2i of register 1, where 0 means read without address, 1 write without address, 2 read with address and 3 write with address.
- R4: A frame holds the opcode MSB first with SCK idle low, and the flash is sampled on the rising edge. Types 2 and 3 append flash_addr[23:0] as three bytes, MSB first.
- R5: A data phase of count+1 bytes happens only when data enable is set. Write types send buffer bytes 0..n-1. Read types store the received bytes into buffer bytes 0..n-1 and touch no other buffer byte.
- R6: In atomic mode a one-byte frame goes out first: register 1 bits 7:0 when prefix select is 0, bits 15:8 when it is 1. Chip select then returns high before the main frame starts.
- R7: Atomic mode on a read-type entry (type 0 or 2) sets cycle error, sends nothing and leaves busy at 0.
- R8: Busy stays high from the accepted go until the last frame ends, and done is then set. Writing one to bits 2, 3 or 4 of register 0 clears that flag. If hardware sets a flag in the same cycle as software clears it, the set wins.
- R9: Go written while busy is ignored and sets access error. The configuration fields keep their values while busy.
- R10: While lock_in is high, writes to registers 1, 2 and 3 are ignored.
- R11: smi_req is high exactly when done and interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 prefix/type, 2 menu low, 3 menu high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lock_in | input | 1 | Lock from hardware sequencer |
| flash_addr | input | 24 | Shared flash address register |
| buf_raddr | output | 6 | Data buffer read index |
| buf_rdata | input | 8 | Data buffer read byte |
| buf_we | output | 1 | Data buffer write enable |
| buf_waddr | output | 6 | Data buffer write index |
| buf_wdata | output | 8 | Data buffer write byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| smi_req | output | 1 | Completion interrupt request |

## Verification
Two events can fall in the same cycle: the hardware setting done when a frame ends, and a software write-one-to-clear of done. The bench provokes the collision without counting cycles. It keeps a done-clearing write asserted on every cycle of a running command, so the final write lands on the completion edge. It then requires done to read 1 afterwards, and to read 0 after one further clearing write. A second collision, go arriving while busy, is judged by the access-error flag, the unchanged index and count fields, and the length of the frame actually sent.

// File: rtl/flash_menu_seq.sv
module flash_menu_seq #(
  parameter int GAP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lock_in,
  input  logic [23:0] flash_addr,
  output logic [5:0]  buf_raddr,
  input  logic [7:0]  buf_rdata,
  output logic        buf_we,
  output logic [5:0]  buf_waddr,
  output logic [7:0]  buf_wdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        smi_req
);
  localparam int GW = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {PH_PFX, PH_GAP, PH_CMD, PH_ADR, PH_DAT} ph_t;

  logic [31:0] menu_lo, menu_hi, ptype_q;
  logic        smi_en, dph, psel, atom;
  logic [5:0]  dbc;
  logic [2:0]  idx;
  logic        busy, done, cerr, aerr;
  ph_t         ph;
  logic [2:0]  bitcnt;
  logic        half, sck_q, cs_q;
  logic [7:0]  sh_q, rx_q, cmd_op;
  logic [1:0]  cur_ty, acnt;
  logic [6:0]  didx;
  logic [GW-1:0] gcnt;

  wire       wr_ctl = reg_wr && reg_addr == 2'd0;
  wire       go_req = wr_ctl && reg_wdata[9];
  wire [2:0] n_idx  = reg_wdata[14:12];
  wire [7:0] n_op   = n_idx[2] ? menu_hi[{n_idx[1:0], 3'b000} +: 8]
                               : menu_lo[{n_idx[1:0], 3'b000} +: 8];
  wire [1:0] n_ty   = ptype_q[16 + {n_idx, 1'b0} +: 2];
  wire       refuse = reg_wdata[10] && !n_ty[0];
  wire       start  = go_req && !busy && !refuse;
  wire       byte_end = busy && ph != PH_GAP && half && bitcnt == 3'd7;
  wire       last_dat = didx == ({1'b0, dbc} + 7'd1);

  assign spi_cs_n  = cs_q;
  assign spi_sck   = sck_q;
  assign spi_mosi  = sh_q[7];
  assign buf_raddr = didx[5:0];
  assign buf_waddr = didx[5:0] - 6'd1;
  assign buf_wdata = rx_q;
  assign buf_we    = byte_end && ph == PH_DAT && !cur_ty[0];
  assign smi_req   = done && smi_en;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {8'b0, smi_en, dph, dbc, 1'b0, idx, psel, atom,
                            5'b0, aerr, cerr, done, 1'b0, busy};
      2'd1:    reg_rdata = ptype_q;
      2'd2:    reg_rdata = menu_lo;
      default: reg_rdata = menu_hi;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      menu_lo <= '0; menu_hi <= '0; ptype_q <= '0;
      smi_en <= 1'b0; dph <= 1'b0; psel <= 1'b0; atom <= 1'b0;
      dbc <= '0; idx <= '0;
      busy <= 1'b0; done <= 1'b0; cerr <= 1'b0; aerr <= 1'b0;
      ph <= PH_CMD; bitcnt <= '0; half <= 1'b0; sck_q <= 1'b0; cs_q <= 1'b1;
      sh_q <= '0; rx_q <= '0; cmd_op <= '0; cur_ty <= '0; acnt <= '0;
      didx <= '0; gcnt <= '0;
    end else begin
      if (reg_wr && !lock_in) begin
        case (reg_addr)
          2'd1: ptype_q <= reg_wdata;
          2'd2: menu_lo <= reg_wdata;
          2'd3: menu_hi <= reg_wdata;
          default: ;
        endcase
      end
      if (wr_ctl && !busy) begin
        smi_en <= reg_wdata[23];
        dph    <= reg_wdata[22];
        dbc    <= reg_wdata[21:16];
        idx    <= reg_wdata[14:12];
        psel   <= reg_wdata[11];
        atom   <= reg_wdata[10];
      end
      if (wr_ctl && reg_wdata[2]) done <= 1'b0;
      if (wr_ctl && reg_wdata[3]) cerr <= 1'b0;
      if (wr_ctl && reg_wdata[4]) aerr <= 1'b0;
      if (go_req && busy) aerr <= 1'b1;
      if (go_req && !busy && refuse) cerr <= 1'b1;

      if (start) begin
        busy   <= 1'b1;
        cs_q   <= 1'b0;
        sck_q  <= 1'b0;
        half   <= 1'b0;
        bitcnt <= '0;
        didx   <= '0;
        acnt   <= '0;
        cmd_op <= n_op;
        cur_ty <= n_ty;
        if (reg_wdata[10]) begin
          ph   <= PH_PFX;
          sh_q <= reg_wdata[11] ? ptype_q[15:8] : ptype_q[7:0];
        end else begin
          ph   <= PH_CMD;
          sh_q <= n_op;
        end
      end else if (busy) begin
        if (ph == PH_GAP) begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            gcnt <= '0;
            cs_q <= 1'b0;
            ph   <= PH_CMD;
            sh_q <= cmd_op;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end else if (!half) begin
          sck_q <= 1'b1;
          half  <= 1'b1;
          rx_q  <= {rx_q[6:0], spi_miso};
        end else begin
          sck_q  <= 1'b0;
          half   <= 1'b0;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt != 3'd7) begin
            sh_q <= {sh_q[6:0], 1'b0};
          end else begin
            case (ph)
              PH_PFX: begin
                cs_q <= 1'b1;
                gcnt <= '0;
                ph   <= PH_GAP;
              end
              PH_CMD: begin
                if (cur_ty[1]) begin
                  ph   <= PH_ADR;
                  acnt <= '0;
                  sh_q <= flash_addr[23:16];
                end else if (dph) begin
                  ph   <= PH_DAT;
                  sh_q <= buf_rdata;
                  didx <= 7'd1;
                end else begin
                  busy <= 1'b0; cs_q <= 1'b1; done <= 1'b1;
                end
              end
              PH_ADR: begin
                if (acnt != 2'd2) begin
                  acnt <= acnt + 1'b1;
                  sh_q <= (acnt == 2'd0) ? flash_addr[15:8] : flash_addr[7:0];
                end else if (dph) begin
                  ph   <= PH_DAT;
                  sh_q <= buf_rdata;
                  didx <= 7'd1;
                end else begin
                  busy <= 1'b0; cs_q <= 1'b1; done <= 1'b1;
                end
              end
              default: begin
                if (last_dat) begin
                  busy <= 1'b0; cs_q <= 1'b1; done <= 1'b1;
                end else begin
                  sh_q <= buf_rdata;
                  didx <= didx + 7'd1;
                end
              end
            endcase
          end
        end
      end
    end
  end
endmodule

module flash_menu_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        go_bit,
  input logic        atom_bit,
  input logic [2:0]  idx_bits,
  input logic        menu_wr_locked,
  input logic [31:0] menu_lo,
  input logic [15:0] types,
  input logic        busy,
  input logic        done,
  input logic        cerr,
  input logic        aerr,
  input logic        cs_n,
  input logic        sck,
  input logic        smi_req
);
  p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_refuse_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && go_bit && atom_bit && !busy && !types[{idx_bits, 1'b0}])
      |=> (!busy && cerr && cs_n));
  p_go_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && go_bit && busy) |=> aerr);
  p_lock_menu_r10: assert property (@(posedge clk) disable iff (!rst_n)
    menu_wr_locked |=> $stable(menu_lo));
  p_smi_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> done);
endmodule

bind flash_menu_seq flash_menu_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .ctl_wr(reg_wr && reg_addr == 2'd0),
  .go_bit(reg_wdata[9]), .atom_bit(reg_wdata[10]), .idx_bits(reg_wdata[14:12]),
  .menu_wr_locked(reg_wr && lock_in && reg_addr == 2'd2),
  .menu_lo(menu_lo), .types(ptype_q[31:16]),
  .busy(busy), .done(done), .cerr(cerr), .aerr(aerr),
  .cs_n(spi_cs_n), .sck(spi_sck), .smi_req(smi_req)
);

// File: tb/flash_menu_seq_tb.sv
module flash_menu_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, lock_in = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [23:0] flash_addr = '0;
  logic [5:0] buf_raddr, buf_waddr;
  logic [7:0] buf_rdata, buf_wdata;
  logic buf_we, spi_cs_n, spi_sck, spi_mosi, spi_miso, smi_req;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_menu_seq u_dut (.*);

  logic [7:0] bufmem [0:63];
  assign buf_rdata = bufmem[buf_raddr];
  always @(posedge clk) if (buf_we) bufmem[buf_waddr] <= buf_wdata;

  function automatic logic [7:0] spat(int p);
    return 8'hC3 ^ 8'(p * 13);
  endfunction
  function automatic logic [7:0] op_of(int i);
    return 8'(8'h03 + i * 8'h1D);
  endfunction
  localparam logic [7:0] PRE0 = 8'h06, PRE1 = 8'h50;

  int fr_cnt = 0, bit_cnt = 0;
  logic [7:0] sh_in = '0;
  logic [7:0] cap [0:3][0:79];
  int clen [0:3];
  logic [7:0] sbyte;
  assign sbyte = spat(bit_cnt / 8);
  assign spi_miso = sbyte[3'(7 - bit_cnt % 8)];

  always @(negedge spi_cs_n) begin
    bit_cnt = 0;
    fr_cnt = fr_cnt + 1;
    if (fr_cnt <= 4) clen[fr_cnt-1] = 0;
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    int fi;
    fi = (fr_cnt >= 1 && fr_cnt <= 4) ? fr_cnt - 1 : 3;
    sh_in = {sh_in[6:0], spi_mosi};
    bit_cnt = bit_cnt + 1;
    if (bit_cnt % 8 == 0 && bit_cnt / 8 <= 80) begin
      cap[fi][bit_cnt/8-1] = sh_in;
      clen[fi] = bit_cnt / 8;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctlw(int i, bit at, bit ps, bit dp, int n, bit go);
    return (32'(dp) << 22) | (32'(n) << 16) | (32'(i) << 12) | (32'(ps) << 11)
         | (32'(at) << 10) | (32'(go) << 9) | 32'h1C;
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int c = 0; c < 5000; c++) begin
      rd(2'd0, s);
      if (!s[0]) return;
    end
    chk("R8 busy timeout", 32'd1, 32'd0);
  endtask

  task automatic cmd(int i, bit at, bit ps, bit dp, int n);
    int ty, hdr, nd, m, bad;
    logic [31:0] s;
    ty = i % 4;
    hdr = 1 + (ty >= 2 ? 3 : 0);
    nd = dp ? n + 1 : 0;
    m = at ? 1 : 0;
    flash_addr = 24'h0A0B0C + 24'(i) * 24'h111111 + 24'(n);
    for (int k = 0; k < 64; k++)
      bufmem[k] <= (ty % 2 == 1) ? 8'(8'h5A + k * 3 + i) : 8'hEE;
    fr_cnt = 0;
    wr(2'd0, ctlw(i, at, ps, dp, n, 1'b1));
    wait_idle();
    chk($sformatf("R6 frame count idx%0d", i), 32'(fr_cnt), 32'(m + 1));
    if (at) begin
      chk("R6 prefix frame length", 32'(clen[0]), 32'd1);
      chk("R6 prefix opcode", 32'(cap[0][0]), 32'(ps ? PRE1 : PRE0));
    end
    chk($sformatf("R3 opcode idx%0d", i), 32'(cap[m][0]), 32'(op_of(i)));
    chk($sformatf("R5 frame length idx%0d", i), 32'(clen[m]), 32'(hdr + nd));
    if (ty >= 2)
      chk("R4 address bytes", {8'h0, cap[m][1], cap[m][2], cap[m][3]}, {8'h0, flash_addr});
    bad = 0;
    for (int k = 0; k < 64; k++) begin
      if (ty % 2 == 1) begin
        if (k < nd && cap[m][hdr+k] !== 8'(8'h5A + k * 3 + i)) bad++;
      end else begin
        if (k < nd && bufmem[k] !== spat(hdr + k)) bad++;
        if (k >= nd && bufmem[k] !== 8'hEE) bad++;
      end
    end
    chk($sformatf("R5 data bytes idx%0d", i), 32'(bad), 32'd0);
    rd(2'd0, s);
    chk("R8 done set, no error", {29'b0, s[4:2]}, 32'd1);
  endtask

  initial begin
    logic [31:0] s;
    for (int k = 0; k < 64; k++) bufmem[k] <= 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 cs idle", 32'(spi_cs_n), 32'd1);
    chk("R1 sck idle", 32'(spi_sck), 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), s);
      chk($sformatf("R1 reg %0d reset", a), s, 32'd0);
    end
    rst_n = 1'b1;

    wr(2'd0, 32'h00EF_7DE0);
    rd(2'd0, s);
    chk("R2 control readback", s, 32'h00EF_7C00);

    wr(2'd1, {16'hE4E4, PRE1, PRE0});
    wr(2'd2, {op_of(3), op_of(2), op_of(1), op_of(0)});
    wr(2'd3, {op_of(7), op_of(6), op_of(5), op_of(4)});
    rd(2'd2, s);
    chk("R3 menu low readback", s, {op_of(3), op_of(2), op_of(1), op_of(0)});

    lock_in = 1'b1;
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd3, 32'hCAFE_F00D);
    rd(2'd1, s); chk("R10 locked type reg", s, {16'hE4E4, PRE1, PRE0});
    rd(2'd2, s); chk("R10 locked menu low", s, {op_of(3), op_of(2), op_of(1), op_of(0)});
    rd(2'd3, s); chk("R10 locked menu high", s, {op_of(7), op_of(6), op_of(5), op_of(4)});
    lock_in = 1'b0;

    for (int i = 0; i < 8; i++) cmd(i, 1'b0, 1'b0, 1'b1, i * 9);
    cmd(2, 1'b0, 1'b0, 1'b1, 63);
    cmd(0, 1'b0, 1'b0, 1'b1, 0);
    for (int i = 0; i < 8; i++) cmd(i, 1'b0, 1'b0, 1'b0, 5);
    for (int i = 1; i < 8; i += 2) begin
      cmd(i, 1'b1, 1'b0, i >= 4, 3);
      cmd(i, 1'b1, 1'b1, i < 4, 7);
    end
    cmd(3, 1'b1, 1'b0, 1'b0, 0);

    for (int i = 0; i < 8; i += 2) begin
      fr_cnt = 0;
      wr(2'd0, ctlw(i, 1'b1, 1'b0, 1'b1, 2, 1'b1));
      repeat (4) @(negedge clk);
      rd(2'd0, s);
      chk($sformatf("R7 refused idx%0d status", i), {27'b0, s[4:0]}, 32'h08);
      chk("R7 nothing sent", 32'(fr_cnt), 32'd0);
    end

    fr_cnt = 0;
    wr(2'd0, ctlw(1, 1'b0, 1'b0, 1'b1, 63, 1'b1));
    wr(2'd0, ctlw(5, 1'b0, 1'b0, 1'b1, 2, 1'b1) & ~32'h1C);
    rd(2'd0, s);
    chk("R9 access error on busy go", 32'(s[4]), 32'd1);
    chk("R9 fields held", {26'b0, s[21:16]}, 32'd63);
    chk("R9 index held", {29'b0, s[14:12]}, 32'd1);
    wait_idle();
    chk("R9 original frame length", 32'(clen[0]), 32'd65);
    chk("R9 single frame", 32'(fr_cnt), 32'd1);
    wr(2'd0, 32'h10);
    rd(2'd0, s);
    chk("R8 W1C access error", {27'b0, s[4:0]}, 32'h04);

    wr(2'd0, ctlw(3, 1'b0, 1'b0, 1'b1, 10, 1'b1));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h4;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      #1;
      if (!reg_rdata[0]) break;
    end
    reg_wr = 1'b0;
    rd(2'd0, s);
    chk("R8 set wins over clear", 32'(s[2]), 32'd1);

    wr(2'd0, 32'h0080_0000);
    @(negedge clk); #1;
    chk("R11 interrupt with done", 32'(smi_req), 32'd1);
    wr(2'd0, 32'h0080_0004);
    rd(2'd0, s);
    chk("R8 W1C done", 32'(s[2]), 32'd0);
    chk("R11 interrupt cleared", 32'(smi_req), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule